// File: doc/BRIEF.md
# Hall Switch Comparator with Hysteresis

This block turns a stream of signed three-axis magnetic field results into one active-low switch output. It behaves like a Hall-effect switch. Exactly one axis is watched: the first of X, Y and Z, in that order, whose 8-bit threshold code is non-zero. Each new result on that axis is compared with the threshold. The output turns on when the field reaches the threshold. It turns off only when the field drops below the threshold by a programmable hysteresis band.

Two switching styles are offered. Unipolar mode compares the signed field with the signed threshold. Omnipolar mode compares the magnitude of the field with the magnitude of the threshold, so either magnet pole operates the switch.

The comparator is live only under these conditions:
- the sensor is in continuous measurement,
- the interrupt-mode field selects one of the two switch modes,
- the band select is above 1,
- at least one threshold is programmed.

While it is live, the interrupt request and the external conversion trigger that pass through the block are forced low.

Top module: `hall_switch_top`

## Requirements
- R1: While rst_ni is low, and on the first cycle after it is released, switch_n_o is 1 (switch off).
- R2: The watched axis is the first of X, Y, Z whose threshold code is non-zero. Only that axis's valid strobe and field value can change the switch state.
- R3: A threshold code c, taken as 8-bit two's complement, stands for the field value c*256 on the 16-bit result scale. A code of 0 removes that axis from comparison. If all three codes are 0, the switch stays off.
- R4: In unipolar mode (int_mode_i = 5), a valid sample with field >= threshold turns the switch on.
- R5: Once on, the switch turns off only on a valid sample with field < threshold - hysteresis. Samples from threshold - hysteresis up to just below the threshold leave it unchanged in either state.
- R6: For band_sel_i = b with b from 2 to 7, the hysteresis is 2^(b+5) counts on the 16-bit scale, which is 2^(b+1) LSB at 12-bit resolution: 128 counts for b=2, rising to 4096 for b=7.
- R7: In omnipolar mode (int_mode_i = 6), the rules of R4 and R5 apply to |field| and |threshold|. A field of -32768 counts as 32768.
- R8: The comparator is active only when all of these hold: op_mode_i = 2 (continuous measurement), int_mode_i is 5 or 6, band_sel_i > 1, and at least one threshold is non-zero. When it is not active, the switch is off after the next clock edge.
- R9: While the comparator is active, irq_req_o and trig_req_o are 0. Otherwise they equal irq_req_i and trig_req_i.
- R10: The switch state changes only at the clock edge that samples the selected axis's valid strobe high. Without that strobe, the state is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_mode_i | input | 2 | Measurement mode; 2 = continuous |
| int_mode_i | input | 3 | Interrupt mode; 5 = unipolar switch, 6 = omnipolar switch |
| band_sel_i | input | 3 | Hysteresis band select; valid range 2 to 7 |
| thr_x_i | input | 8 | X threshold code, two's complement, 0 = off |
| thr_y_i | input | 8 | Y threshold code, two's complement, 0 = off |
| thr_z_i | input | 8 | Z threshold code, two's complement, 0 = off |
| field_x_i | input | 16 | X field result, signed |
| field_y_i | input | 16 | Y field result, signed |
| field_z_i | input | 16 | Z field result, signed |
| valid_x_i | input | 1 | New X result strobe |
| valid_y_i | input | 1 | New Y result strobe |
| valid_z_i | input | 1 | New Z result strobe |
| irq_req_i | input | 1 | Interrupt request from the interrupt logic |
| trig_req_i | input | 1 | External conversion trigger |
| switch_n_o | output | 1 | Switch output, active low |
| irq_req_o | output | 1 | Interrupt request after the switch-mode override |
| trig_req_o | output | 1 | Conversion trigger after the switch-mode override |

## Verification
A vector sequence moves the field in steps across both edges of the hysteresis window. It places samples exactly at the threshold, exactly at threshold minus band, and one count either side of each. This separates a >= from a > comparison and shows that the window is held from both directions.

Further vectors do the following:
- They change the band from narrowest to widest, which distinguishes the hysteresis widths.
- They move the first non-zero threshold from X to Y to Z, while the other axes carry values that would switch if they were wrongly selected.
- They use negative fields in omnipolar mode, including the most negative code, and a negative threshold in unipolar mode. This separates signed comparison from magnitude comparison.

Directed steps then check each enable condition, the override of interrupt and trigger, strobes on an unselected axis, holding of state without a strobe, and reset.

// File: rtl/hsw_pkg.sv
package hsw_pkg;
  localparam int N_AX = 3;

  typedef enum logic [1:0] {
    OPM_STANDBY = 2'd0,
    OPM_SLEEP   = 2'd1,
    OPM_CONT    = 2'd2,
    OPM_RSVD    = 2'd3
  } op_mode_e;

  localparam logic [2:0] SWM_UNIPOLAR  = 3'd5;
  localparam logic [2:0] SWM_OMNIPOLAR = 3'd6;
  localparam logic [2:0] BAND_MIN      = 3'd2;

  function automatic logic is_switch_mode(input logic [2:0] m);
    return (m == SWM_UNIPOLAR) || (m == SWM_OMNIPOLAR);
  endfunction
endpackage

// File: rtl/hsw_axis_pick.sv
module hsw_axis_pick #(
  parameter int N_AX   = 3,
  parameter int THR_W  = 8,
  parameter int DATA_W = 16
) (
  input  logic [N_AX-1:0][THR_W-1:0]  thr_i,
  input  logic [N_AX-1:0][DATA_W-1:0] field_i,
  input  logic [N_AX-1:0]             valid_i,
  output logic [N_AX-1:0]             sel_o,
  output logic                        any_o,
  output logic [THR_W-1:0]            thr_o,
  output logic [DATA_W-1:0]           field_o,
  output logic                        valid_o
);
  // fixed priority: lowest index (X) wins
  always_comb begin
    logic found;
    found = 1'b0;
    sel_o = '0;
    for (int i = 0; i < N_AX; i++) begin
      if (!found && (thr_i[i] != '0)) begin
        sel_o[i] = 1'b1;
        found    = 1'b1;
      end
    end
    any_o = found;
  end

  always_comb begin
    thr_o   = '0;
    field_o = '0;
    valid_o = 1'b0;
    for (int i = 0; i < N_AX; i++) begin
      if (sel_o[i]) begin
        thr_o   = thr_o | thr_i[i];
        field_o = field_o | field_i[i];
        valid_o = valid_o | valid_i[i];
      end
    end
  end
endmodule

// File: rtl/hsw_level.sv
module hsw_level #(
  parameter int DATA_W = 16,
  parameter int THR_W  = 8,
  parameter int RES_W  = 12,
  localparam int CMP_W      = DATA_W + 2,
  localparam int THR_SHIFT  = DATA_W - THR_W,
  localparam int HYST_SHIFT = DATA_W - RES_W
) (
  input  logic                    omni_i,
  input  logic [2:0]              band_i,
  input  logic [THR_W-1:0]        thr_i,
  input  logic [DATA_W-1:0]       field_i,
  output logic signed [CMP_W-1:0] lvl_o,
  output logic signed [CMP_W-1:0] on_lvl_o,
  output logic signed [CMP_W-1:0] off_lvl_o
);
  logic signed [CMP_W-1:0] f_ext, t_ext, hyst;
  logic [4:0]              hyst_sh;

  assign f_ext = {{(CMP_W-DATA_W){field_i[DATA_W-1]}}, field_i};
  assign t_ext = {{(CMP_W-THR_W){thr_i[THR_W-1]}}, thr_i} <<< THR_SHIFT;

  // band b -> 2^(b+1) LSB at RES_W resolution
  assign hyst_sh = 5'(band_i) + 5'd1 + 5'(HYST_SHIFT);
  assign hyst    = CMP_W'(1) << hyst_sh;

  always_comb begin
    if (omni_i) begin
      lvl_o    = (f_ext < 0) ? -f_ext : f_ext;
      on_lvl_o = (t_ext < 0) ? -t_ext : t_ext;
    end else begin
      lvl_o    = f_ext;
      on_lvl_o = t_ext;
    end
    off_lvl_o = on_lvl_o - hyst;
  end
endmodule

// File: rtl/hsw_hyst.sv
module hsw_hyst #(
  parameter int CMP_W = 18
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic                    valid_i,
  input  logic signed [CMP_W-1:0] lvl_i,
  input  logic signed [CMP_W-1:0] on_lvl_i,
  input  logic signed [CMP_W-1:0] off_lvl_i,
  output logic                    sw_on_o
);
  logic sw_on_q, sw_on_d;

  always_comb begin
    sw_on_d = sw_on_q;
    if (!en_i)                                   sw_on_d = 1'b0;
    else if (valid_i && !sw_on_q && lvl_i >= on_lvl_i) sw_on_d = 1'b1;
    else if (valid_i &&  sw_on_q && lvl_i < off_lvl_i) sw_on_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sw_on_q <= 1'b0;
    else         sw_on_q <= sw_on_d;
  end

  assign sw_on_o = sw_on_q;

  assert_release_inactive_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !sw_on_q);

  assert_hold_no_strobe_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !valid_i) |=> $stable(sw_on_q));

  assert_turn_on_at_thr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sw_on_q) |-> $past(en_i && valid_i && (lvl_i >= on_lvl_i)));

  assert_turn_off_below_band_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(sw_on_q) && $past(en_i)) |-> $past(valid_i && (lvl_i < off_lvl_i)));
endmodule

// File: rtl/hall_switch_top.sv
module hall_switch_top #(
  parameter int DATA_W = 16,
  parameter int THR_W  = 8,
  parameter int RES_W  = 12,
  localparam int CMP_W = DATA_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        op_mode_i,
  input  logic [2:0]        int_mode_i,
  input  logic [2:0]        band_sel_i,
  input  logic [THR_W-1:0]  thr_x_i,
  input  logic [THR_W-1:0]  thr_y_i,
  input  logic [THR_W-1:0]  thr_z_i,
  input  logic [DATA_W-1:0] field_x_i,
  input  logic [DATA_W-1:0] field_y_i,
  input  logic [DATA_W-1:0] field_z_i,
  input  logic              valid_x_i,
  input  logic              valid_y_i,
  input  logic              valid_z_i,
  input  logic              irq_req_i,
  input  logic              trig_req_i,
  output logic              switch_n_o,
  output logic              irq_req_o,
  output logic              trig_req_o
);
  import hsw_pkg::*;

  logic [N_AX-1:0]             sel;
  logic                        any_thr, sel_valid, active, sw_on;
  logic [THR_W-1:0]            sel_thr;
  logic [DATA_W-1:0]           sel_field;
  logic signed [CMP_W-1:0]     lvl, on_lvl, off_lvl;

  hsw_axis_pick #(.N_AX(N_AX), .THR_W(THR_W), .DATA_W(DATA_W)) i_pick (
    .thr_i   ({thr_z_i, thr_y_i, thr_x_i}),
    .field_i ({field_z_i, field_y_i, field_x_i}),
    .valid_i ({valid_z_i, valid_y_i, valid_x_i}),
    .sel_o   (sel),
    .any_o   (any_thr),
    .thr_o   (sel_thr),
    .field_o (sel_field),
    .valid_o (sel_valid)
  );

  assign active = (op_mode_i == OPM_CONT) && is_switch_mode(int_mode_i) &&
                  (band_sel_i >= BAND_MIN) && any_thr;

  hsw_level #(.DATA_W(DATA_W), .THR_W(THR_W), .RES_W(RES_W)) i_level (
    .omni_i    (int_mode_i == SWM_OMNIPOLAR),
    .band_i    (band_sel_i),
    .thr_i     (sel_thr),
    .field_i   (sel_field),
    .lvl_o     (lvl),
    .on_lvl_o  (on_lvl),
    .off_lvl_o (off_lvl)
  );

  hsw_hyst #(.CMP_W(CMP_W)) i_hyst (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (active),
    .valid_i   (sel_valid),
    .lvl_i     (lvl),
    .on_lvl_i  (on_lvl),
    .off_lvl_i (off_lvl),
    .sw_on_o   (sw_on)
  );

  assign switch_n_o = ~sw_on;
  assign irq_req_o  = irq_req_i  & ~active;
  assign trig_req_o = trig_req_i & ~active;

  assert_override_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active |-> (!irq_req_o && !trig_req_o));

  assert_x_first_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (thr_x_i != '0) |-> (sel == 3'b001));

  assert_y_before_z_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((thr_x_i == '0) && (thr_y_i != '0)) |-> (sel == 3'b010));

  assert_zero_codes_off_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((thr_x_i == '0) && (thr_y_i == '0) && (thr_z_i == '0)) |=> switch_n_o);
endmodule

// File: tb/test_hall_switch_top.sv
module test_hall_switch_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  op_mode = 2'd2;
  logic [2:0]  int_mode = 3'd0, band_sel = 3'd0;
  logic [7:0]  thr_x = 8'd0, thr_y = 8'd0, thr_z = 8'd0;
  logic [15:0] fx = 16'd0, fy = 16'd0, fz = 16'd0;
  logic        vx = 1'b0, vy = 1'b0, vz = 1'b0;
  logic        irq_i = 1'b0, trig_i = 1'b0;
  logic        switch_n, irq_o, trig_o;
  int          errors = 0, checks = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  hall_switch_top i_hall_switch_top (
    .clk_i(clk), .rst_ni(rst_ni), .op_mode_i(op_mode), .int_mode_i(int_mode),
    .band_sel_i(band_sel), .thr_x_i(thr_x), .thr_y_i(thr_y), .thr_z_i(thr_z),
    .field_x_i(fx), .field_y_i(fy), .field_z_i(fz),
    .valid_x_i(vx), .valid_y_i(vy), .valid_z_i(vz),
    .irq_req_i(irq_i), .trig_req_i(trig_i),
    .switch_n_o(switch_n), .irq_req_o(irq_o), .trig_req_o(trig_o)
  );

  typedef struct packed {
    logic [2:0]  md;
    logic [2:0]  bs;
    logic [7:0]  tx, ty, tz;
    logic [15:0] x, y, z;
    logic        on;
  } vec_t;

  localparam int NV = 21;
  // the expected switch state follows R3..R7 applied to the running history
  localparam vec_t VECS [NV] = '{
    '{3'd5, 3'd2, 8'h10, 8'h00, 8'h00, 16'd4095,  16'd0,    16'd0,    1'b0},
    '{3'd5, 3'd2, 8'h10, 8'h00, 8'h00, 16'd4096,  16'd0,    16'd0,    1'b1},
    '{3'd5, 3'd2, 8'h10, 8'h00, 8'h00, 16'd4000,  16'd0,    16'd0,    1'b1},
    '{3'd5, 3'd2, 8'h10, 8'h00, 8'h00, 16'd3968,  16'd0,    16'd0,    1'b1},
    '{3'd5, 3'd2, 8'h10, 8'h00, 8'h00, 16'd3967,  16'd0,    16'd0,    1'b0},
    '{3'd5, 3'd2, 8'h10, 8'h00, 8'h00, 16'd4000,  16'd0,    16'd0,    1'b0},
    '{3'd5, 3'd7, 8'h10, 8'h00, 8'h00, 16'd5000,  16'd0,    16'd0,    1'b1},
    '{3'd5, 3'd7, 8'h10, 8'h00, 8'h00, 16'd0,     16'd0,    16'd0,    1'b1},
    '{3'd5, 3'd7, 8'h10, 8'h00, 8'h00, 16'hFFFF,  16'd0,    16'd0,    1'b0},
    '{3'd5, 3'd2, 8'h00, 8'h08, 8'h20, 16'd9999,  16'd2048, 16'd0,    1'b1},
    '{3'd5, 3'd2, 8'h00, 8'h08, 8'h20, 16'd9999,  16'd1000, 16'd9000, 1'b0},
    '{3'd5, 3'd2, 8'h00, 8'h00, 8'h20, 16'd9999,  16'd9999, 16'd8192, 1'b1},
    '{3'd5, 3'd2, 8'h00, 8'h00, 8'h20, 16'd9999,  16'd9999, 16'd8063, 1'b0},
    '{3'd6, 3'd3, 8'hF0, 8'h00, 8'h00, 16'hF000,  16'd0,    16'd0,    1'b1},
    '{3'd6, 3'd3, 8'hF0, 8'h00, 8'h00, 16'd3900,  16'd0,    16'd0,    1'b1},
    '{3'd6, 3'd3, 8'hF0, 8'h00, 8'h00, 16'hF101,  16'd0,    16'd0,    1'b0},
    '{3'd6, 3'd3, 8'hF0, 8'h00, 8'h00, 16'h8000,  16'd0,    16'd0,    1'b1},
    '{3'd6, 3'd3, 8'hF0, 8'h00, 8'h00, 16'd4100,  16'd0,    16'd0,    1'b1},
    '{3'd5, 3'd2, 8'hF0, 8'h00, 8'h00, 16'hF000,  16'd0,    16'd0,    1'b1},
    '{3'd5, 3'd2, 8'hF0, 8'h00, 8'h00, 16'hEF7F,  16'd0,    16'd0,    1'b0},
    '{3'd5, 3'd2, 8'hF0, 8'h00, 8'h00, 16'hEF80,  16'd0,    16'd0,    1'b0}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one edge with the given strobes high, then strobes low; sample at negedge
  task automatic pulse(input logic sx, input logic sy, input logic sz);
    vx = sx; vy = sy; vz = sz;
    @(posedge clk);
    @(negedge clk);
    vx = 1'b0; vy = 1'b0; vz = 1'b0;
  endtask

  task automatic idle_edge();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 in reset", switch_n, 1);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1 after reset", switch_n, 1);

    // vector walk: R2..R7 with R10 timing (one edge after strobe)
    for (int i = 0; i < NV; i++) begin
      int_mode = VECS[i].md; band_sel = VECS[i].bs;
      thr_x = VECS[i].tx; thr_y = VECS[i].ty; thr_z = VECS[i].tz;
      fx = VECS[i].x; fy = VECS[i].y; fz = VECS[i].z;
      pulse(1'b1, 1'b1, 1'b1);
      check($sformatf("R4/R5/R6/R7/R2 vector %0d", i), switch_n, int'(!VECS[i].on));
    end

    // R8: not in continuous mode
    int_mode = 3'd5; band_sel = 3'd2; thr_x = 8'h10; thr_y = 8'h00; thr_z = 8'h00;
    op_mode = 2'd1; irq_i = 1'b1; trig_i = 1'b1; fx = 16'd8000;
    pulse(1'b1, 1'b0, 1'b0);
    check("R8 sleep mode keeps off", switch_n, 1);
    check("R9 irq passes when inactive", irq_o, 1);
    check("R9 trig passes when inactive", trig_o, 1);

    op_mode = 2'd2;
    @(negedge clk);
    check("R9 irq forced low", irq_o, 0);
    check("R9 trig forced low", trig_o, 0);
    check("R10 no change without strobe", switch_n, 1);
    pulse(1'b1, 1'b0, 1'b0);
    check("R4 on in continuous", switch_n, 0);

    // R10 / R2: hold without strobe, ignore strobe on unselected axis
    fx = 16'd0;
    idle_edge();
    check("R10 held without strobe", switch_n, 0);
    pulse(1'b0, 1'b1, 1'b1);
    check("R2 unselected strobe ignored", switch_n, 0);
    pulse(1'b1, 1'b0, 1'b0);
    check("R5 off on selected strobe", switch_n, 1);

    // R8: band select 1 releases
    fx = 16'd8000;
    pulse(1'b1, 1'b0, 1'b0);
    check("R4 on again", switch_n, 0);
    band_sel = 3'd1;
    idle_edge();
    check("R8 band 1 releases", switch_n, 1);
    check("R9 irq passes with band 1", irq_o, 1);

    // R8: non-switch interrupt mode releases
    band_sel = 3'd2;
    pulse(1'b1, 1'b0, 1'b0);
    check("R4 on with band 2", switch_n, 0);
    int_mode = 3'd4;
    idle_edge();
    check("R8 mode 4 releases", switch_n, 1);
    pulse(1'b1, 1'b0, 1'b0);
    check("R8 mode 4 stays off", switch_n, 1);

    // R3: all codes zero
    int_mode = 3'd5; thr_x = 8'h00;
    fx = 16'h7FFF; fy = 16'h7FFF; fz = 16'h7FFF;
    pulse(1'b1, 1'b1, 1'b1);
    check("R3 zero codes never switch", switch_n, 1);
    check("R9 irq passes with zero codes", irq_o, 1);

    // R1: reset while on
    thr_x = 8'h10; fx = 16'd8000;
    pulse(1'b1, 1'b0, 1'b0);
    check("R4 on before reset", switch_n, 0);
    rst_ni = 1'b0;
    #1;
    check("R1 async reset releases", switch_n, 1);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1 off after reset release", switch_n, 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule